// File: doc/BRIEF.md
# Voice Channel Serial Receive Packer

This block takes one bearer channel of a time-division serial line and turns it into 32-bit words for a host processor. While a slot window is open, a bit-rate enable marks the cycles that carry data. Eight accepted bits form one sample, and one sample arrives in every 8 kHz frame. Four consecutive samples are packed into one word. The sample received first goes into the top byte.

A finished word moves through a shadow stage into a holding register that the host reads. At that moment an interrupt flag is raised, which happens once every four frames (2 kHz). Assembly of the next word carries on while the host has not yet read. If the host is slow, an overrun flag records that a word was lost. A mode input sets the bit order. Raw voice arrives most significant bit first. Bit-stuffed link data arrives least significant bit first. The mode can change between samples.

Top module: `bchan_rx_packer`

## Requirements
- R1: With `lsb_first` = 0, the first accepted bit of a sample lands in sample bit 7 and the eighth accepted bit lands in bit 0.
- R2: With `lsb_first` = 1, the first accepted bit lands in sample bit 0 and the eighth lands in bit 7. The mode may differ from one sample to the next.
- R3: A bit is taken from `ser_in` only in a cycle where `bit_en` and `slot_act` are both 1. Eight such bits complete one sample.
- R4: Four consecutive samples form one word: the first in bits 31:24, the second in 23:16, the third in 15:8 and the fourth in 7:0.
- R5: A completed word appears on `word_out` and `irq` rises two clock edges after the edge that accepted the word's last bit.
- R6: `word_out` changes only when a word is transferred. Assembly of the following word goes on while `irq` is still set.
- R7: A one-cycle `rd_ack` pulse clears `irq` and `ovr` at the next edge.
- R8: If a word is transferred while `irq` is still set and `rd_ack` is low in that cycle, `ovr` is set and the new word replaces the old one.
- R9: A synchronous `rst` clears `word_out`, `irq`, `ovr`, the bit count and the sample count. A partly built word is dropped.
- R10: If `slot_act` falls before eight bits are taken, the partial sample is thrown away. The next slot starts a fresh sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous reset, active high |
| bit_en | input | 1 | Bit-rate enable, one cycle per line bit |
| slot_act | input | 1 | Slot window of this channel |
| lsb_first | input | 1 | Bit order: 0 = msb first, 1 = lsb first |
| ser_in | input | 1 | Serial data from the line |
| rd_ack | input | 1 | Host read strobe, clears the flags |
| word_out | output | 32 | Holding register read by the host |
| irq | output | 1 | Word-ready interrupt flag |
| ovr | output | 1 | Overrun flag |

## Verification
A scoreboard predicts each word from the byte values and the bit order it drove, so a packer that reversed the byte order or ignored the mode would deliver mismatching words. The serial input is toggled between enable pulses, which exposes a design that samples without `bit_en`. Short slot windows are placed before and inside a word, so a design that kept partial samples would shift every later byte. Directed steps also cover the following:
- the exact two-edge latency of the interrupt;
- a holding register that stays unchanged while the next word assembles;
- an overrun caused by an unread word, which a design without overwrite or without the flag would miss;
- a reset in the middle of a word, which a design that kept its byte count would follow with misaligned words.

// File: rtl/bchan_pkg.sv
`timescale 1ns/1ps
package bchan_pkg;
  typedef enum logic {
    ORDER_MSB = 1'b0,
    ORDER_LSB = 1'b1
  } bit_order_e;

  localparam int unsigned DEF_SAMPLE_W = 8;
  localparam int unsigned DEF_SAMPLES  = 4;
endpackage

// File: rtl/bchan_bit_shifter.sv
`timescale 1ns/1ps
module bchan_bit_shifter
  import bchan_pkg::*;
#(
  parameter int unsigned SAMPLE_W = DEF_SAMPLE_W
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                bit_en,
  input  logic                slot_act,
  input  logic                lsb_first,
  input  logic                ser_in,
  output logic                samp_vld,
  output logic [SAMPLE_W-1:0] samp_data
);
  localparam int unsigned CW = $clog2(SAMPLE_W);
  localparam logic [CW-1:0] LAST_BIT = CW'(SAMPLE_W - 1);

  logic [SAMPLE_W-1:0] sh_q;
  logic [CW-1:0]       cnt_q;
  logic                take;
  logic [SAMPLE_W-1:0] sh_nxt;

  function automatic logic [SAMPLE_W-1:0] shift_in(
    input logic [SAMPLE_W-1:0] cur,
    input logic                d,
    input bit_order_e          ord
  );
    if (ord == ORDER_LSB) return {d, cur[SAMPLE_W-1:1]};
    return {cur[SAMPLE_W-2:0], d};
  endfunction

  assign take   = bit_en && slot_act;
  assign sh_nxt = shift_in(sh_q, ser_in, bit_order_e'(lsb_first));

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_q      <= '0;
      cnt_q     <= '0;
      samp_vld  <= 1'b0;
      samp_data <= '0;
    end else begin
      samp_vld <= 1'b0;
      if (!slot_act) begin
        cnt_q <= '0;
      end else if (take) begin
        sh_q <= sh_nxt;
        if (cnt_q == LAST_BIT) begin
          cnt_q     <= '0;
          samp_vld  <= 1'b1;
          samp_data <= sh_nxt;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/bchan_word_packer.sv
`timescale 1ns/1ps
module bchan_word_packer
  import bchan_pkg::*;
#(
  parameter int unsigned SAMPLE_W = DEF_SAMPLE_W,
  parameter int unsigned SAMPLES  = DEF_SAMPLES,
  localparam int unsigned WORD_W  = SAMPLE_W * SAMPLES
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                samp_vld,
  input  logic [SAMPLE_W-1:0] samp_data,
  output logic                word_vld,
  output logic [WORD_W-1:0]   word_data
);
  localparam int unsigned ACC_W = WORD_W - SAMPLE_W;
  localparam int unsigned KW    = $clog2(SAMPLES);
  localparam logic [KW-1:0] LAST_SAMP = KW'(SAMPLES - 1);

  logic [ACC_W-1:0]  acc_q;
  logic [KW-1:0]     k_q;
  logic [WORD_W-1:0] merged;

  function automatic logic [WORD_W-1:0] append_sample(
    input logic [ACC_W-1:0]    acc,
    input logic [SAMPLE_W-1:0] s
  );
    return {acc, s};
  endfunction

  assign merged = append_sample(acc_q, samp_data);

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q     <= '0;
      k_q       <= '0;
      word_vld  <= 1'b0;
      word_data <= '0;
    end else begin
      word_vld <= 1'b0;
      if (samp_vld) begin
        acc_q <= merged[ACC_W-1:0];
        if (k_q == LAST_SAMP) begin
          k_q       <= '0;
          word_vld  <= 1'b1;
          word_data <= merged;
        end else begin
          k_q <= k_q + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/bchan_host_hold.sv
`timescale 1ns/1ps
module bchan_host_hold #(
  parameter int unsigned WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              word_vld,
  input  logic [WORD_W-1:0] word_data,
  input  logic              rd_ack,
  output logic [WORD_W-1:0] word_out,
  output logic              irq,
  output logic              ovr
);
  logic lost_word;

  assign lost_word = word_vld && irq && !rd_ack;

  always_ff @(posedge clk) begin
    if (rst) begin
      word_out <= '0;
      irq      <= 1'b0;
      ovr      <= 1'b0;
    end else begin
      if (word_vld) word_out <= word_data;
      irq <= word_vld || (irq && !rd_ack);
      ovr <= lost_word || (ovr && !rd_ack);
    end
  end
endmodule

// File: rtl/bchan_rx_packer.sv
`timescale 1ns/1ps
module bchan_rx_packer
  import bchan_pkg::*;
#(
  parameter int unsigned SAMPLE_W = DEF_SAMPLE_W,
  parameter int unsigned SAMPLES  = DEF_SAMPLES,
  localparam int unsigned WORD_W  = SAMPLE_W * SAMPLES
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bit_en,
  input  logic              slot_act,
  input  logic              lsb_first,
  input  logic              ser_in,
  input  logic              rd_ack,
  output logic [WORD_W-1:0] word_out,
  output logic              irq,
  output logic              ovr
);
  logic                samp_vld;
  logic [SAMPLE_W-1:0] samp_data;
  logic                word_vld;
  logic [WORD_W-1:0]   word_data;

  bchan_bit_shifter #(.SAMPLE_W(SAMPLE_W)) shifter_i (
    .clk(clk), .rst(rst), .bit_en(bit_en), .slot_act(slot_act),
    .lsb_first(lsb_first), .ser_in(ser_in),
    .samp_vld(samp_vld), .samp_data(samp_data)
  );

  bchan_word_packer #(.SAMPLE_W(SAMPLE_W), .SAMPLES(SAMPLES)) packer_i (
    .clk(clk), .rst(rst), .samp_vld(samp_vld), .samp_data(samp_data),
    .word_vld(word_vld), .word_data(word_data)
  );

  bchan_host_hold #(.WORD_W(WORD_W)) hold_i (
    .clk(clk), .rst(rst), .word_vld(word_vld), .word_data(word_data),
    .rd_ack(rd_ack), .word_out(word_out), .irq(irq), .ovr(ovr)
  );
endmodule

// File: rtl/bchan_rx_packer_chk.sv
`timescale 1ns/1ps
module bchan_rx_packer_chk #(
  parameter int unsigned WORD_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              bit_en,
  input logic              slot_act,
  input logic              rd_ack,
  input logic              samp_vld,
  input logic              word_vld,
  input logic [WORD_W-1:0] word_out,
  input logic              irq,
  input logic              ovr
);
  AST_SAMPLE_NEEDS_BIT: assert property (@(posedge clk) disable iff (rst)
    samp_vld |-> $past(bit_en && slot_act)); // R3
  AST_WORD_AFTER_SAMPLE: assert property (@(posedge clk) disable iff (rst)
    word_vld |-> $past(samp_vld)); // R4
  AST_IRQ_ON_WORD: assert property (@(posedge clk) disable iff (rst)
    word_vld |=> irq); // R5
  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (rst)
    !word_vld |=> $stable(word_out)); // R6
  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (rd_ack && !word_vld) |=> (!irq && !ovr)); // R7
  AST_OVERRUN_SET: assert property (@(posedge clk) disable iff (rst)
    (word_vld && irq && !rd_ack) |=> ovr); // R8
endmodule

bind bchan_rx_packer bchan_rx_packer_chk #(.WORD_W(WORD_W)) chk_i (
  .clk(clk), .rst(rst), .bit_en(bit_en), .slot_act(slot_act),
  .rd_ack(rd_ack), .samp_vld(samp_vld), .word_vld(word_vld),
  .word_out(word_out), .irq(irq), .ovr(ovr)
);

// File: tb/bchan_rx_packer_tb_top.sv
`timescale 1ns/1ps
module bchan_rx_packer_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bit_en = 1'b0;
  logic        slot_act = 1'b0;
  logic        lsb_first = 1'b0;
  logic        ser_in = 1'b0;
  logic        rd_ack;
  logic [31:0] word_out;
  logic        irq;
  logic        ovr;

  int n_chk = 0;
  int n_fail = 0;
  bit mon_en = 1'b1;
  logic [31:0] exp_q[$];
  logic [31:0] asm_w = '0;
  int asm_n = 0;
  logic [31:0] held;

  always #4 clk = ~clk;

  bchan_rx_packer dut_i (
    .clk(clk), .rst(rst), .bit_en(bit_en), .slot_act(slot_act),
    .lsb_first(lsb_first), .ser_in(ser_in), .rd_ack(rd_ack),
    .word_out(word_out), .irq(irq), .ovr(ovr)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  // Driver: sends one sample in the chosen bit order, predicts words.
  task automatic send_sample(input logic [7:0] v, input logic lsb);
    lsb_first = lsb;
    @(negedge clk) slot_act = 1'b1;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      ser_in = lsb ? v[i] : v[7-i];
      bit_en = 1'b1;
      @(negedge clk);
      bit_en = 1'b0;
      ser_in = ~ser_in;  // noise between enables (R3)
    end
    @(negedge clk) slot_act = 1'b0;
    asm_w = {asm_w[23:0], v};
    asm_n++;
    if (asm_n == 4) begin
      exp_q.push_back(asm_w);
      asm_n = 0;
    end
  endtask

  task automatic send_partial(input int nbits);
    @(negedge clk) slot_act = 1'b1;
    for (int i = 0; i < nbits; i++) begin
      @(negedge clk);
      ser_in = 1'b1;
      bit_en = 1'b1;
      @(negedge clk);
      bit_en = 1'b0;
    end
    @(negedge clk) slot_act = 1'b0;
  endtask

  // Monitor: pops expected words and acknowledges them.
  initial begin
    rd_ack = 1'b0;
    forever begin
      @(negedge clk);
      if (rd_ack) begin
        rd_ack = 1'b0;
        chk("R7 irq cleared by ack", {31'b0, irq}, 32'd0);
      end else if (mon_en && irq) begin
        if (exp_q.size() == 0) chk("R4 unexpected word", word_out, 32'hxxxxxxxx);
        else chk("R4 word packing", word_out, exp_q.pop_front());
        rd_ack = 1'b1;
      end
    end
  end

  initial begin
    #(8 * 200000);
    n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    summary();
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R9 reset word", word_out, 32'd0);
    chk("R9 reset irq", {31'b0, irq}, 32'd0);
    chk("R9 reset ovr", {31'b0, ovr}, 32'd0);

    // R1 msb first
    send_sample(8'hA1, 1'b0); send_sample(8'hB2, 1'b0);
    send_sample(8'hC3, 1'b0); send_sample(8'hD4, 1'b0);
    // R2 lsb first
    send_sample(8'h01, 1'b1); send_sample(8'h80, 1'b1);
    send_sample(8'h5C, 1'b1); send_sample(8'hE7, 1'b1);
    // R2 mode switched between samples
    send_sample(8'h3A, 1'b0); send_sample(8'h3A, 1'b1);
    send_sample(8'hF0, 1'b1); send_sample(8'h0F, 1'b0);
    // R10 partial slots are dropped
    send_partial(5);
    send_sample(8'h12, 1'b0); send_sample(8'h34, 1'b1);
    send_partial(3);
    send_sample(8'h56, 1'b0); send_sample(8'h78, 1'b0);
    repeat (6) @(negedge clk);
    chk("R10 words after partial slots delivered", exp_q.size(), 32'd0);

    // R5 latency, R6 hold, R8 overrun with the host idle
    mon_en = 1'b0;
    send_sample(8'h11, 1'b0); send_sample(8'h22, 1'b0);
    send_sample(8'h33, 1'b0); send_sample(8'h44, 1'b0);
    chk("R5 irq low one edge after last bit", {31'b0, irq}, 32'd0);
    @(negedge clk);
    chk("R5 irq high two edges after last bit", {31'b0, irq}, 32'd1);
    held = exp_q.pop_front();
    chk("R5 word at transfer", word_out, held);
    send_sample(8'h55, 1'b1); send_sample(8'h66, 1'b0);
    chk("R6 holding unchanged during assembly", word_out, held);
    chk("R6 irq still set", {31'b0, irq}, 32'd1);
    send_sample(8'h77, 1'b0); send_sample(8'h88, 1'b1);
    @(negedge clk);
    chk("R8 overrun flagged", {31'b0, ovr}, 32'd1);
    chk("R8 new word replaces old", word_out, exp_q[0]);
    mon_en = 1'b1;
    repeat (4) @(negedge clk);
    chk("R7 ovr cleared by ack", {31'b0, ovr}, 32'd0);

    // R9 reset in the middle of a word
    send_sample(8'h9A, 1'b0); send_sample(8'hBC, 1'b0);
    @(negedge clk) rst = 1'b1;
    @(negedge clk) rst = 1'b0;
    asm_w = '0;
    asm_n = 0;
    chk("R9 mid-word reset clears holding", word_out, 32'd0);
    send_sample(8'hDE, 1'b0); send_sample(8'hAD, 1'b0);
    send_sample(8'hBE, 1'b1); send_sample(8'hEF, 1'b0);
    repeat (6) @(negedge clk);
    chk("R9 all words delivered after reset", exp_q.size(), 32'd0);

    summary();
    $finish;
  end
endmodule